// File: doc/BRIEF.md
# MicroWire Half-Duplex Serial Master

This block is a register-mapped serial master for MicroWire-style peripherals. A processor reaches it through a small word-indexed register bus. Through that bus it loads a transmit word, configures each of four peripheral selects, and launches a transfer. The engine then drives the serial clock and data-out pins, or samples data-in. A single launch either shifts a word out or shifts a word in, never both. Each word is 1 to 16 bits long.

Every chip select has its own 6-bit mode field. The field chooses the clock edge that launches output bits, the edge that captures input bits, the active level of the select line, and a divide of 2, 4 or 8 applied to an external prescaler tick. That tick arrives on its own input. A global register makes the idle level of the serial clock high.

Software waits for the busy flag to drop before it changes the select. After a read it waits for the receive-ready flag and then fetches the received word. Fetching the word clears the flag.

Top module: `uwire_master`

## Requirements
- R1: Word index 2 holds the mode fields of selects 0 (bits 5:0) and 1 (bits 11:6), and index 3 holds those of selects 2 (bits 5:0) and 3 (bits 11:6). Upper bits of both read as zero. Index 4 keeps bits 2:0, which read back and appear on `clk_setup_o`. Index 5 keeps bit 0.
- R2: After reset all registers are zero, all four select lines are high, and the serial clock and data-out are low.
- R3: Index 1 reads as {ready[15], busy[14], 0[13], assert[12], select[11:10], out-count[9:5], in-count[4:0]}. Bit 13 of a write is the launch command and is never stored.
- R4: Busy is set on the cycle after a launch is accepted. It drops on the same edge as the falling transition of the internal clock that ends the last bit.
- R5: A launch with a nonzero out-count sends that many bits of the transmit word (index 0), starting from bit 15. Its in-count is ignored and ready is left unchanged. Counts above 16 act as 16, and data-out returns low at the end.
- R6: A launch with a zero out-count and nonzero in-count shifts in that many bits, right-aligned with the last bit in bit 0. At the end it sets ready. Reading index 0 returns the word and clears ready.
- R7: Mode bit 1 set moves output bits on the internal rising edge (first bit at the first rising edge); clear moves them on falling edges (first bit at launch). Mode bit 0 set captures on the internal falling edge; clear captures on the rising edge.
- R8: Mode bits 4:3 equal to 0, 1, or 2/3 give a serial period of 2, 4 or 8 tick pulses, half high and half low. The clock only changes on a tick, so a transfer of N bits with a tick every cycle keeps busy for N times the divide.
- R9: Select line k is active only when the assert bit is set and the select field equals k. Active level is high when bit 2 of its mode field is set, else low. An inactive line sits at the opposite level.
- R10: The serial clock pin is the internal clock inverted when bit 0 of index 5 is set, so it idles high.
- R11: A write to index 1 while busy is ignored entirely: no field changes and no new launch.
- R12: A launch with both counts zero does not set busy, does not toggle the clock and does not change ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaler pulse that paces the serial clock |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on index 0) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed index |
| sdi | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| cs_o | output | 4 | Chip-select lines |
| clk_setup_o | output | 3 | Stored clock-setup bits for the external prescaler |

## Verification
The assertions assume that software never rewrites a mode register while busy is set. They also assume that `tick` and `sdi` are settled before each clock edge. Under those conditions the select lines and clock stay stable between tick pulses. The stimulus changes mode and invert registers only after the reference model shows the engine idle. The one mid-transfer register write is the control write that must be ignored. `sdi` is driven from a fixed pattern or a free-running shift sequence at the falling system clock edge.

// File: rtl/uw_pkg.sv
package uw_pkg;

    localparam int DATA_W  = 16;
    localparam int NUM_CS  = 4;
    localparam int CNT_W   = 5;
    localparam int ADDR_W  = 3;
    localparam int MODE_W  = 6;
    localparam int SEL_W   = $clog2(NUM_CS);
    localparam int HCNT_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        IDX_DATA   = 3'd0,
        IDX_CTRL   = 3'd1,
        IDX_MODE_A = 3'd2,
        IDX_MODE_B = 3'd3,
        IDX_CLKSET = 3'd4,
        IDX_CLKINV = 3'd5
    } reg_idx_e;

    typedef struct packed {
        logic       rdy_chk;
        logic [1:0] div_sel;
        logic       cs_high;
        logic       drive_rise;
        logic       sample_fall;
    } cs_mode_t;

    typedef struct packed {
        logic             assert_cs;
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] wcnt;
        logic [CNT_W-1:0] rcnt;
    } ctrl_t;

    function automatic logic [HCNT_W-1:0] half_ticks(input logic [1:0] d);
        case (d)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] clamp_bits(input logic [CNT_W-1:0] n);
        if (n > CNT_W'(DATA_W)) return CNT_W'(DATA_W);
        return n;
    endfunction

endpackage

// File: rtl/uw_regs.sv
module uw_regs
    import uw_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                busy,
    input  logic                done,
    input  logic                done_is_read,
    input  logic [DATA_W-1:0]   rx_final,
    output logic [DATA_W-1:0]   reg_rdata,
    output ctrl_t               ctrl_q,
    output logic [DATA_W-1:0]   tx_q,
    output logic [NUM_CS-1:0]   cs_high_v,
    output logic                start,
    output logic [1:0]          st_div,
    output logic                st_drive_rise,
    output logic                st_sample_fall,
    output logic [2:0]          clk_setup_q,
    output logic                clk_inv_q,
    output logic                rdy_q
);

    cs_mode_t          mode_q [NUM_CS];
    logic [DATA_W-1:0] rx_q;
    logic              ctrl_wr;
    logic [SEL_W-1:0]  new_sel;
    cs_mode_t          new_mode;

    assign ctrl_wr  = reg_wr && (reg_addr == IDX_CTRL);
    assign new_sel  = reg_wdata[11:10];
    assign new_mode = mode_q[new_sel];
    assign start    = ctrl_wr && !busy && reg_wdata[13] && (|reg_wdata[9:0]);
    assign st_div         = new_mode.div_sel;
    assign st_drive_rise  = new_mode.drive_rise;
    assign st_sample_fall = new_mode.sample_fall;

    // Per-select mode fields, two per register word.
    for (genvar j = 0; j < NUM_CS; j++) begin : g_mode
        localparam logic [ADDR_W-1:0] RIDX = ADDR_W'(int'(IDX_MODE_A) + j / 2);
        localparam int SH = (j % 2) * MODE_W;
        always_ff @(posedge clk) begin
            if (rst)
                mode_q[j] <= '0;
            else if (reg_wr && reg_addr == RIDX)
                mode_q[j] <= cs_mode_t'(reg_wdata[SH +: MODE_W]);
        end
        assign cs_high_v[j] = mode_q[j].cs_high;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            tx_q        <= '0;
            rx_q        <= '0;
            clk_setup_q <= '0;
            clk_inv_q   <= 1'b0;
            rdy_q       <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == IDX_DATA)   tx_q        <= reg_wdata;
            if (reg_wr && reg_addr == IDX_CLKSET) clk_setup_q <= reg_wdata[2:0];
            if (reg_wr && reg_addr == IDX_CLKINV) clk_inv_q   <= reg_wdata[0];
            if (ctrl_wr && !busy)                 ctrl_q      <= ctrl_t'(reg_wdata[12:0]);
            if (done && done_is_read) begin
                rx_q  <= rx_final;
                rdy_q <= 1'b1;
            end else if (reg_rd && reg_addr == IDX_DATA) begin
                rdy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            IDX_DATA:   reg_rdata = rx_q;
            IDX_CTRL:   reg_rdata = {rdy_q, busy, 1'b0, ctrl_q};
            IDX_CLKSET: reg_rdata[2:0] = clk_setup_q;
            IDX_CLKINV: reg_rdata[0] = clk_inv_q;
            default: begin
                for (int j = 0; j < NUM_CS; j++) begin
                    if (int'(reg_addr) == int'(IDX_MODE_A) + j / 2)
                        reg_rdata[(j % 2) * MODE_W +: MODE_W] = mode_q[j];
                end
            end
        endcase
    end

endmodule

// File: rtl/uw_shift.sv
module uw_shift
    import uw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  logic [CNT_W-1:0]  wcnt_in,
    input  logic [CNT_W-1:0]  rcnt_in,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [1:0]        div_in,
    input  logic              drive_rise_in,
    input  logic              sample_fall_in,
    input  logic              sdi,
    output logic              busy,
    output logic              sck,
    output logic              sdo,
    output logic              done,
    output logic              is_read,
    output logic [DATA_W-1:0] rx_final
);

    logic [1:0]        div_q;
    logic              drive_rise_q, sample_fall_q, writing;
    logic [HCNT_W-1:0] hcnt;
    logic [CNT_W-1:0]  left, nbits;
    logic [DATA_W-1:0] shreg, rx_sh, rx_next;
    logic              half_end, rise_ev, fall_ev;

    always_comb begin
        half_end = busy && tick && (hcnt == half_ticks(div_q) - 3'd1);
        rise_ev  = half_end && !sck;
        fall_ev  = half_end && sck;
        done     = fall_ev && (left == CNT_W'(1));
        rx_next  = {rx_sh[DATA_W-2:0], sdi};
        rx_final = sample_fall_q ? rx_next : rx_sh;
        is_read  = !writing;
        nbits    = clamp_bits((wcnt_in != '0) ? wcnt_in : rcnt_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; sck <= 1'b0; sdo <= 1'b0; hcnt <= '0; left <= '0;
            writing <= 1'b0; shreg <= '0; rx_sh <= '0;
            div_q <= '0; drive_rise_q <= 1'b0; sample_fall_q <= 1'b0;
        end else if (start && !busy) begin
            busy          <= 1'b1;
            sck           <= 1'b0;
            hcnt          <= '0;
            left          <= nbits;
            writing       <= (wcnt_in != '0);
            div_q         <= div_in;
            drive_rise_q  <= drive_rise_in;
            sample_fall_q <= sample_fall_in;
            rx_sh         <= '0;
            if (wcnt_in != '0 && !drive_rise_in) begin
                sdo   <= tx_word[DATA_W-1];
                shreg <= tx_word << 1;
            end else begin
                sdo   <= 1'b0;
                shreg <= tx_word;
            end
        end else if (busy && tick) begin
            if (half_end) begin
                hcnt <= '0;
                sck  <= ~sck;
                if (rise_ev) begin
                    if (writing && drive_rise_q) begin
                        sdo   <= shreg[DATA_W-1];
                        shreg <= shreg << 1;
                    end
                    if (!writing && !sample_fall_q) rx_sh <= rx_next;
                end
                if (fall_ev) begin
                    if (!writing && sample_fall_q) rx_sh <= rx_next;
                    if (left == CNT_W'(1)) begin
                        busy <= 1'b0;
                        sdo  <= 1'b0;
                    end else begin
                        left <= left - CNT_W'(1);
                        if (writing && !drive_rise_q) begin
                            sdo   <= shreg[DATA_W-1];
                            shreg <= shreg << 1;
                        end
                    end
                end
            end else begin
                hcnt <= hcnt + 3'd1;
            end
        end
    end

endmodule

// File: rtl/uw_cs_drive.sv
module uw_cs_drive
    import uw_pkg::*;
(
    input  logic              assert_cs,
    input  logic [SEL_W-1:0]  sel,
    input  logic [NUM_CS-1:0] cs_high_v,
    output logic [NUM_CS-1:0] cs_o
);

    for (genvar k = 0; k < NUM_CS; k++) begin : g_line
        logic act;
        assign act     = assert_cs && (sel == SEL_W'(k));
        assign cs_o[k] = act ? cs_high_v[k] : ~cs_high_v[k];
    end

endmodule

// File: rtl/uwire_master.sv
module uwire_master
    import uw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              sdi,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic [3:0]        cs_o,
    output logic [2:0]        clk_setup_o
);

    ctrl_t             ctrl_w;
    logic [DATA_W-1:0] tx_w, rx_final_w;
    logic [NUM_CS-1:0] cs_high_w;
    logic              start_w, busy_w, done_w, is_read_w, sck_w;
    logic [1:0]        st_div_w;
    logic              st_dr_w, st_sf_w, clk_inv_w, rdy_w;

    uw_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .busy(busy_w), .done(done_w), .done_is_read(is_read_w),
        .rx_final(rx_final_w), .reg_rdata(reg_rdata), .ctrl_q(ctrl_w),
        .tx_q(tx_w), .cs_high_v(cs_high_w), .start(start_w),
        .st_div(st_div_w), .st_drive_rise(st_dr_w), .st_sample_fall(st_sf_w),
        .clk_setup_q(clk_setup_o), .clk_inv_q(clk_inv_w), .rdy_q(rdy_w)
    );

    uw_shift u_shift (
        .clk(clk), .rst(rst), .tick(tick), .start(start_w),
        .wcnt_in(reg_wdata[9:5]), .rcnt_in(reg_wdata[4:0]), .tx_word(tx_w),
        .div_in(st_div_w), .drive_rise_in(st_dr_w), .sample_fall_in(st_sf_w),
        .sdi(sdi), .busy(busy_w), .sck(sck_w), .sdo(sdo_o), .done(done_w),
        .is_read(is_read_w), .rx_final(rx_final_w)
    );

    uw_cs_drive u_cs (
        .assert_cs(ctrl_w.assert_cs), .sel(ctrl_w.sel),
        .cs_high_v(cs_high_w), .cs_o(cs_o)
    );

    assign sclk_o = sck_w ^ clk_inv_w;

endmodule

// File: rtl/uwire_master_chk.sv
module uwire_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [2:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        sclk_o,
    input logic        busy,
    input logic        done,
    input logic        start,
    input logic        rdy,
    input logic        clk_inv,
    input logic [12:0] ctrl
);

    // R4: accepted launch raises busy on the next cycle
    p_busy_rise_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R4: completion of the last bit drops busy
    p_busy_fall_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R10: idle clock pin sits at the invert level
    p_idle_level_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk_o == clk_inv));

    // R8: no clock movement without a tick unless the invert bit is rewritten
    p_tick_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (!tick && !(reg_wr && reg_addr == 3'd5)) |=> $stable(sclk_o));

    // R12: launch with both counts zero leaves the engine idle
    p_zero_count_r12: assert property (@(posedge clk) disable iff (rst)
        (!busy && reg_wr && reg_addr == 3'd1 && reg_wdata[13] && reg_wdata[9:0] == 10'd0)
        |=> !busy);

    // R11: control fields hold when written during a transfer
    p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_addr == 3'd1) |=> $stable(ctrl));

    // R6: fetching the received word clears ready
    p_rdy_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 3'd0 && !done) |=> !rdy);

endmodule

bind uwire_master uwire_master_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .sclk_o(sclk_o),
    .busy(busy_w), .done(done_w), .start(start_w), .rdy(rdy_w),
    .clk_inv(clk_inv_w), .ctrl(ctrl_w)
);

// File: tb/uwire_master_test.sv
`timescale 1ns/1ps
module uwire_master_test;

    logic clk = 1'b0, rst = 1'b1, tick = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0, sdi = 1'b0;
    logic [2:0]  reg_addr = 3'd1;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic sclk_o, sdo_o;
    logic [3:0] cs_o;
    logic [2:0] clk_setup_o;

    uwire_master uut (.clk(clk), .rst(rst), .tick(tick), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sdi(sdi),
        .sclk_o(sclk_o), .sdo_o(sdo_o), .cs_o(cs_o), .clk_setup_o(clk_setup_o));

    always #5 clk = ~clk;

    int errs = 0, checks = 0, cyc = 0;
    int tick_div = 1, tick_cnt = 0;
    bit sdi_one = 0;
    logic [15:0] lfsr = 16'hACE1;

    // bench-side slave view
    bit bench_inv = 0, sl_drv_rise = 0, sl_prev = 0, sl_prev_sdo = 0;
    logic [15:0] cap;
    int edges = 0, toggles = 0, busy_cyc = 0;

    // reference model state
    bit m_busy, m_sck, m_isw, m_sdo, m_rdy, m_as, m_inv;
    int m_h, m_left;
    logic [15:0] m_sh, m_rxs, m_rxq, m_tx;
    logic [5:0] m_mode [4];
    logic [5:0] m_cfg;
    logic [1:0] m_sel;
    logic [4:0] m_wc, m_rc;
    logic [2:0] m_cs3;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    always @(negedge clk) begin
        tick_cnt++;
        tick = (tick_div == 1) || (tick_cnt % tick_div == 0);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sdi  = sdi_one ? 1'b1 : lfsr[0];
    end

    function automatic logic [15:0] exp_rdata();
        case (reg_addr)
            3'd0: return m_rxq;
            3'd1: return {m_rdy, m_busy, 1'b0, m_as, m_sel, m_wc, m_rc};
            3'd2: return {4'b0, m_mode[1], m_mode[0]};
            3'd3: return {4'b0, m_mode[3], m_mode[2]};
            3'd4: return {13'b0, m_cs3};
            3'd5: return {15'b0, m_inv};
            default: return 16'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit b0, fin;
        int hf, n;
        cyc++;
        if (rst) begin
            m_busy = 0; m_sck = 0; m_isw = 0; m_sdo = 0; m_rdy = 0; m_as = 0; m_inv = 0;
            m_h = 0; m_left = 0; m_sh = 0; m_rxs = 0; m_rxq = 0; m_tx = 0;
            foreach (m_mode[i]) m_mode[i] = 0;
            m_cfg = 0; m_sel = 0; m_wc = 0; m_rc = 0; m_cs3 = 0;
        end else begin
            b0 = m_busy; fin = 0;
            if (m_busy && tick) begin
                hf = (m_cfg[4:3] == 0) ? 1 : (m_cfg[4:3] == 1) ? 2 : 4;
                if (m_h == hf - 1) begin
                    m_h = 0;
                    if (!m_sck) begin
                        m_sck = 1;
                        if (m_isw && m_cfg[1]) begin m_sdo = m_sh[15]; m_sh = m_sh << 1; end
                        if (!m_isw && !m_cfg[0]) m_rxs = {m_rxs[14:0], sdi};
                    end else begin
                        m_sck = 0;
                        if (!m_isw && m_cfg[0]) m_rxs = {m_rxs[14:0], sdi};
                        if (m_left == 1) begin m_busy = 0; fin = 1; m_sdo = 0; end
                        else begin
                            m_left--;
                            if (m_isw && !m_cfg[1]) begin m_sdo = m_sh[15]; m_sh = m_sh << 1; end
                        end
                    end
                end else m_h++;
            end
            if (fin && !m_isw) begin m_rxq = m_rxs; m_rdy = 1; end
            else if (reg_rd && reg_addr == 3'd0) m_rdy = 0;
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_tx = reg_wdata;
                    3'd1: if (!b0) begin
                        m_as = reg_wdata[12]; m_sel = reg_wdata[11:10];
                        m_wc = reg_wdata[9:5]; m_rc = reg_wdata[4:0];
                        if (reg_wdata[13] && (m_wc != 0 || m_rc != 0)) begin
                            m_cfg = m_mode[m_sel]; m_isw = (m_wc != 0);
                            n = m_isw ? int'(m_wc) : int'(m_rc);
                            m_left = (n > 16) ? 16 : n;
                            m_busy = 1; m_h = 0; m_sck = 0; m_rxs = 0;
                            if (m_isw && !m_cfg[1]) begin m_sdo = m_tx[15]; m_sh = m_tx << 1; end
                            else begin m_sdo = 0; m_sh = m_tx; end
                        end
                    end
                    3'd2: begin m_mode[0] = reg_wdata[5:0]; m_mode[1] = reg_wdata[11:6]; end
                    3'd3: begin m_mode[2] = reg_wdata[5:0]; m_mode[3] = reg_wdata[11:6]; end
                    3'd4: m_cs3 = reg_wdata[2:0];
                    3'd5: m_inv = reg_wdata[0];
                    default: ;
                endcase
            end
        end
        #1;
        if (!rst) begin
            logic [3:0] ecs;
            for (int k = 0; k < 4; k++)
                ecs[k] = (m_as && m_sel == 2'(k)) ? m_mode[k][2] : !m_mode[k][2];
            check(sclk_o == (m_sck ^ m_inv), "R8", "model sclk", sclk_o, m_sck ^ m_inv);
            check(sdo_o == m_sdo, "R5", "model sdo", sdo_o, m_sdo);
            check(cs_o == ecs, "R9", "model cs", cs_o, ecs);
            check(reg_rdata == exp_rdata(), "R3", "model rdata", reg_rdata, exp_rdata());
            check(clk_setup_o == m_cs3, "R1", "model clk_setup", clk_setup_o, m_cs3);
        end
        if ((sclk_o ^ bench_inv) != sl_prev) begin
            toggles++;
            if ((sclk_o ^ bench_inv) == !sl_drv_rise) begin
                cap = {cap[14:0], sl_prev_sdo};
                edges++;
            end
        end
        sl_prev = sclk_o ^ bench_inv;
        sl_prev_sdo = sdo_o;
        if (reg_addr == 3'd1 && reg_rdata[14]) busy_cyc++;
        if (cyc > 150000) begin
            check(0, "R4", "watchdog expired", cyc, 0);
            finish_run();
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_addr = 3'd1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0; reg_addr = 3'd1;
    endtask

    task automatic launch(input logic [15:0] c);
        cap = 0; edges = 0; toggles = 0; busy_cyc = 0;
        wr(3'd1, c);
    endtask

    task automatic wait_idle();
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    logic [15:0] v;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R2 reset state
        check(cs_o == 4'hF, "R2", "cs after reset", cs_o, 4'hF);
        check(sclk_o == 0 && sdo_o == 0, "R2", "sclk/sdo after reset", {sclk_o, sdo_o}, 0);
        rd(3'd1, v); check(v == 16'h0, "R2", "ctrl after reset", v, 0);
        rd(3'd0, v); check(v == 16'h0, "R2", "data after reset", v, 0);

        // R1 register storage
        wr(3'd2, 16'hFFFF); rd(3'd2, v); check(v == 16'h0FFF, "R1", "mode A", v, 16'h0FFF);
        wr(3'd3, 16'hFABC); rd(3'd3, v); check(v == 16'h0ABC, "R1", "mode B", v, 16'h0ABC);
        wr(3'd4, 16'hFFFD); rd(3'd4, v); check(v == 16'h0005, "R1", "clock setup", v, 5);
        check(clk_setup_o == 3'd5, "R1", "clk_setup_o", clk_setup_o, 5);
        wr(3'd5, 16'h0001); rd(3'd5, v); check(v == 16'h0001, "R1", "invert reg", v, 1);
        check(sclk_o == 1, "R10", "idle high when inverted", sclk_o, 1);
        wr(3'd5, 0); wr(3'd2, 0); wr(3'd3, 0);

        // R9 chip selects: cs3 active high
        wr(3'd3, 16'h0100);
        wr(3'd1, 16'h0C00); check(cs_o == 4'h7, "R9", "cs3 idle low", cs_o, 4'h7);
        wr(3'd1, 16'h1C00); check(cs_o == 4'hF, "R9", "cs3 asserted high", cs_o, 4'hF);
        wr(3'd1, 16'h1400); check(cs_o == 4'h5, "R9", "cs1 asserted low", cs_o, 4'h5);
        wr(3'd3, 0); wr(3'd1, 0);

        // R5 R4 R8: 8-bit write, drive on falling, divide 2
        sl_drv_rise = 0;
        wr(3'd0, 16'hA500); launch(16'h3000 | (8 << 5)); wait_idle();
        check(cap[7:0] == 8'hA5, "R5", "8-bit write data", cap[7:0], 8'hA5);
        check(edges == 8, "R5", "write bit count", edges, 8);
        check(busy_cyc == 16, "R4", "busy length div2", busy_cyc, 16);
        check(sdo_o == 0, "R5", "sdo low after write", sdo_o, 0);

        // R7: drive on rising, divide 4, cs1
        wr(3'd2, 16'h0280); sl_drv_rise = 1;
        wr(3'd0, 16'h5A3C); launch(16'h3400 | (12 << 5)); wait_idle();
        check(cap[11:0] == 12'h5A3, "R7", "rising-edge write", cap[11:0], 12'h5A3);
        check(busy_cyc == 48, "R8", "busy length div4", busy_cyc, 48);
        sl_drv_rise = 0;

        // R5 clamp and write precedence
        wr(3'd0, 16'hBEEF); launch(16'h3000 | (20 << 5) | 5); wait_idle();
        check(cap == 16'hBEEF && edges == 16, "R5", "count clamp to 16", edges, 16);
        rd(3'd1, v); check(v[15] == 0, "R5", "read count ignored on write", v[15], 0);

        // R6 read with data-in held high
        sdi_one = 1;
        launch(16'h3000 | 5); wait_idle();
        rd(3'd1, v); check(v[15] == 1, "R6", "ready set", v[15], 1);
        rd(3'd0, v); check(v == 16'h001F, "R6", "5-bit read", v, 16'h1F);
        rd(3'd1, v); check(v[15] == 0, "R6", "ready cleared", v[15], 0);
        check(sdo_o == 0, "R6", "sdo quiet in read", sdo_o, 0);

        // R7: sample on falling, divide 8, cs2, varying data-in
        sdi_one = 0;
        wr(3'd3, 16'h0011);
        launch(16'h3800 | 16); wait_idle();
        check(busy_cyc == 128, "R8", "busy length div8", busy_cyc, 128);
        rd(3'd0, v); check(v == m_rxq, "R7", "falling-edge read", v, m_rxq);

        // R10 inverted clock write
        wr(3'd5, 1); bench_inv = 1; sl_prev = 0;
        wr(3'd0, 16'h9000); launch(16'h3000 | (4 << 5)); wait_idle();
        check(cap[3:0] == 4'h9, "R10", "write with inverted clock", cap[3:0], 9);
        check(sclk_o == 1, "R10", "idle high after transfer", sclk_o, 1);
        wr(3'd5, 0); bench_inv = 0; sl_prev = 0;

        // R11 control write during transfer
        wr(3'd0, 16'h1234); launch(16'h3000 | (16 << 5));
        repeat (5) @(negedge clk);
        wr(3'd1, 16'h3C05);
        wait_idle();
        rd(3'd1, v);
        check(v[12:0] == 13'h1200, "R11", "ctrl unchanged", v[12:0], 13'h1200);
        check(busy_cyc == 32, "R11", "no relaunch", busy_cyc, 32);

        // R12 zero counts
        launch(16'h3000);
        repeat (10) @(negedge clk);
        check(busy_cyc == 0 && toggles == 0, "R12", "zero count idle", busy_cyc + toggles, 0);
        rd(3'd1, v); check(v[15:14] == 2'b00, "R12", "flags unchanged", v[15:14], 0);

        // R8 sparse ticks
        tick_div = 3;
        wr(3'd0, 16'hC000); launch(16'h3000 | (4 << 5)); wait_idle();
        check(busy_cyc >= 22 && busy_cyc <= 24, "R8", "tick paced length", busy_cyc, 23);
        check(cap[3:0] == 4'hC, "R8", "tick paced data", cap[3:0], 4'hC);
        tick_div = 1;

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule